// File: doc/BRIEF.md
# Rename Undo Log

This block keeps the undo records that a register-renaming stage creates each time it gives a destination register a new physical register. Each record carries four fields: the instruction's sequence number, the architectural register, the physical register just allocated, and the physical register that the architectural register mapped to before. Rename pushes one record per cycle at the young end of the log.

When the pipeline flushes younger work, the log walks back from the young end. Each record it removes writes its previous physical register back into the external map table and returns its new physical register to the external free list. When instructions retire, the log walks forward from the old end and returns each record's previous physical register to the free list.

Both walks handle one record per clock. A busy output holds off rename while a walk runs, and a full output holds it off when the log has no free slot. Two counters report how many records have been retired and how many have been undone.

Top module: `rename_history_buf`

## Requirements
- R1: After reset, busy and full are 0, the map, free and scoreboard strobes are 0, both counters are 0, and the log is empty.
- R2: A push is stored at the young end when busy is 0 and full is 0. A push made while full is 1 is ignored. Full is 1 exactly when Depth records are held.
- R3: A flush request starts a walk that removes one record per clock from the young end for as long as the record's sequence number is unsigned-greater than the flush sequence number. The walk stops at the first record that fails this test, or when the log is empty.
- R4: For each record a flush walk removes, mapWrEn is 1 with mapWrArch equal to the record's architectural register and mapWrPhys equal to its previous physical register. In the same cycle, freeEn is 1 with freePhys equal to its new physical register.
- R5: During a flush walk, sbSetEn is 1 with sbSetPhys equal to the record's new physical register exactly when that register index is at least PhysRegCount.
- R6: A retire request starts a walk that removes one record per clock from the old end for as long as the record's sequence number is unsigned-less-than-or-equal to the retire sequence number. For each removed record, freeEn is 1 with freePhys equal to its previous physical register, while mapWrEn and sbSetEn stay 0.
- R7: A retire request is ignored, with busy staying 0 and no strobe, when the log is empty or when its oldest record's sequence number is greater than the retire sequence number.
- R8: When a flush and a retire are requested in the same cycle, only the flush is acted on. Retire requests made while a walk is running are ignored.
- R9: Busy is 1 from the cycle after an accepted request until the walk ends. Pushes made while busy is 1 are ignored.
- R10: retireCnt increases by one for each record removed by a retire walk, and undoCnt increases by one for each record removed by a flush walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push a new undo record |
| pushSeq | input | SeqW | Sequence number of the renamed instruction |
| pushArch | input | ArchW | Architectural destination register |
| pushNew | input | PhysW | Newly allocated physical register |
| pushPrev | input | PhysW | Previously mapped physical register |
| flushValid | input | 1 | Flush request |
| flushSeq | input | SeqW | Keep records with sequence at or below this |
| retireValid | input | 1 | Retire request |
| retireSeq | input | SeqW | Retire records with sequence at or below this |
| busy | output | 1 | A walk is in progress; pushes are refused |
| full | output | 1 | Log holds Depth records |
| mapWrEn | output | 1 | Map table restore strobe |
| mapWrArch | output | ArchW | Architectural register to restore |
| mapWrPhys | output | PhysW | Physical register to write back |
| freeEn | output | 1 | Free list return strobe |
| freePhys | output | PhysW | Physical register returned |
| sbSetEn | output | 1 | Scoreboard set-ready strobe |
| sbSetPhys | output | PhysW | Register marked ready |
| retireCnt | output | CntW | Records retired so far |
| undoCnt | output | CntW | Records undone so far |

## Verification
The walks are tried in several cases: a flush whose boundary falls in the middle of the log, which shows that the young-end walk stops at the right record; a retire that covers part of the log and then all of it, which shows oldest-first order; and retire requests against an empty log and against a log whose oldest record is too young, which show that such requests are ignored. A flush over a log filled to capacity, after a push made while full, separates an accepted push from a dropped one by the first register freed. A flush and a retire requested in the same cycle show that only the flush acts. A push made during a walk, followed by a later flush that finds nothing to undo, shows that busy blocks pushes.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef struct packed {
    logic push;
    logic popYoung;
    logic popOld;
  } rhbStrobe_t;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_UNDO,
    WALK_RETIRE
  } walkState_t;
endpackage

// File: rtl/rhb_store.sv
module rhb_store
  import rhb_pkg::*;
#(
  parameter int Depth = 8,
  parameter int SeqW  = 8,
  parameter int ArchW = 5,
  parameter int PhysW = 7
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  rhbStrobe_t                      strobe,
  input  logic [SeqW+ArchW+2*PhysW-1:0]   wrRec,
  output logic [SeqW+ArchW+2*PhysW-1:0]   youngRec,
  output logic [SeqW+ArchW+2*PhysW-1:0]   oldRec,
  output logic                            isEmpty,
  output logic                            isFull
);
  localparam int RecW = SeqW + ArchW + 2 * PhysW;
  localparam int PtrW = $clog2(Depth);

  logic [RecW-1:0] slots [Depth];
  logic [PtrW-1:0] oldPtr, newPtr;
  logic [PtrW:0]   fill;

  always_ff @(posedge clk) begin
    if (strobe.push) slots[newPtr] <= wrRec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oldPtr <= '0;
      newPtr <= '0;
      fill   <= '0;
    end else begin
      if (strobe.push)     newPtr <= newPtr + PtrW'(1);
      if (strobe.popYoung) newPtr <= newPtr - PtrW'(1);
      if (strobe.popOld)   oldPtr <= oldPtr + PtrW'(1);
      case ({strobe.push, strobe.popYoung | strobe.popOld})
        2'b10:   fill <= fill + (PtrW+1)'(1);
        2'b01:   fill <= fill - (PtrW+1)'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign youngRec = slots[newPtr - PtrW'(1)];
  assign oldRec   = slots[oldPtr];
  assign isEmpty  = (fill == '0);
  assign isFull   = (fill == (PtrW+1)'(Depth));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !strobe.push);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !(strobe.popYoung || strobe.popOld));
  // R9
  single_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.push, strobe.popYoung, strobe.popOld}) <= 1);
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int SeqW         = 8,
  parameter int ArchW        = 5,
  parameter int PhysW        = 7,
  parameter int PhysRegCount = 96,
  parameter int CntW         = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pushValid,
  input  logic                          flushValid,
  input  logic [SeqW-1:0]               flushSeq,
  input  logic                          retireValid,
  input  logic [SeqW-1:0]               retireSeq,
  input  logic                          isEmpty,
  input  logic                          isFull,
  input  logic [SeqW+ArchW+2*PhysW-1:0] youngRec,
  input  logic [SeqW+ArchW+2*PhysW-1:0] oldRec,
  output rhbStrobe_t                    strobe,
  output logic                          busy,
  output logic                          mapWrEn,
  output logic [ArchW-1:0]              mapWrArch,
  output logic [PhysW-1:0]              mapWrPhys,
  output logic                          freeEn,
  output logic [PhysW-1:0]              freePhys,
  output logic                          sbSetEn,
  output logic [PhysW-1:0]              sbSetPhys,
  output logic [CntW-1:0]               retireCnt,
  output logic [CntW-1:0]               undoCnt
);
  localparam int RecW = SeqW + ArchW + 2 * PhysW;
  localparam logic [PhysW:0] SbLimit = (PhysW+1)'(PhysRegCount);

  walkState_t      st;
  logic [SeqW-1:0] bound;

  logic [SeqW-1:0]  youngSeq, oldSeq;
  logic [ArchW-1:0] youngArch;
  logic [PhysW-1:0] youngNew, youngPrev, oldPrev;
  logic undoGo, retireGo, startUndo, startRetire;

  assign youngSeq  = youngRec[RecW-1 -: SeqW];
  assign youngArch = youngRec[2*PhysW +: ArchW];
  assign youngNew  = youngRec[PhysW +: PhysW];
  assign youngPrev = youngRec[0 +: PhysW];
  assign oldSeq    = oldRec[RecW-1 -: SeqW];
  assign oldPrev   = oldRec[0 +: PhysW];

  assign undoGo      = (st == WALK_UNDO) && !isEmpty && (youngSeq > bound);
  assign retireGo    = (st == WALK_RETIRE) && !isEmpty && (oldSeq <= bound);
  assign startUndo   = flushValid && (st != WALK_UNDO);
  assign startRetire = retireValid && !flushValid && (st == WALK_IDLE) &&
                       !isEmpty && (oldSeq <= retireSeq);

  always_comb begin
    strobe          = '0;
    strobe.push     = pushValid && (st == WALK_IDLE) && !isFull;
    strobe.popYoung = undoGo;
    strobe.popOld   = retireGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= WALK_IDLE;
      bound     <= '0;
      retireCnt <= '0;
      undoCnt   <= '0;
    end else begin
      if (startUndo) begin
        st    <= WALK_UNDO;
        bound <= flushSeq;
      end else if (startRetire) begin
        st    <= WALK_RETIRE;
        bound <= retireSeq;
      end else if ((st == WALK_UNDO && !undoGo) ||
                   (st == WALK_RETIRE && !retireGo)) begin
        st <= WALK_IDLE;
      end
      if (undoGo)   undoCnt   <= undoCnt + CntW'(1);
      if (retireGo) retireCnt <= retireCnt + CntW'(1);
    end
  end

  assign busy      = (st != WALK_IDLE);
  assign mapWrEn   = undoGo;
  assign mapWrArch = youngArch;
  assign mapWrPhys = youngPrev;
  assign freeEn    = undoGo || retireGo;
  assign freePhys  = undoGo ? youngNew : oldPrev;
  assign sbSetEn   = undoGo && ({1'b0, youngNew} >= SbLimit);
  assign sbSetPhys = youngNew;

  // R8
  flush_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    undoGo |=> (st == WALK_UNDO));
  // R6
  retire_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireGo |-> (!mapWrEn && !sbSetEn));
  // R10
  retire_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireGo |=> (retireCnt == $past(retireCnt) + CntW'(1)));
  // R5
  sb_pairs_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    sbSetEn |-> (freeEn && mapWrEn && sbSetPhys == freePhys));
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf
  import rhb_pkg::*;
#(
  parameter int Depth        = 8,
  parameter int SeqW         = 8,
  parameter int ArchW        = 5,
  parameter int PhysW        = 7,
  parameter int PhysRegCount = 96,
  parameter int CntW         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [SeqW-1:0]  pushSeq,
  input  logic [ArchW-1:0] pushArch,
  input  logic [PhysW-1:0] pushNew,
  input  logic [PhysW-1:0] pushPrev,
  input  logic             flushValid,
  input  logic [SeqW-1:0]  flushSeq,
  input  logic             retireValid,
  input  logic [SeqW-1:0]  retireSeq,
  output logic             busy,
  output logic             full,
  output logic             mapWrEn,
  output logic [ArchW-1:0] mapWrArch,
  output logic [PhysW-1:0] mapWrPhys,
  output logic             freeEn,
  output logic [PhysW-1:0] freePhys,
  output logic             sbSetEn,
  output logic [PhysW-1:0] sbSetPhys,
  output logic [CntW-1:0]  retireCnt,
  output logic [CntW-1:0]  undoCnt
);
  localparam int RecW = SeqW + ArchW + 2 * PhysW;

  rhbStrobe_t      strobe;
  logic [RecW-1:0] youngRec, oldRec;
  logic            isEmpty;

  rhb_store #(.Depth(Depth), .SeqW(SeqW), .ArchW(ArchW), .PhysW(PhysW)) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrRec({pushSeq, pushArch, pushNew, pushPrev}),
    .youngRec(youngRec), .oldRec(oldRec), .isEmpty(isEmpty), .isFull(full)
  );

  rhb_ctrl #(.SeqW(SeqW), .ArchW(ArchW), .PhysW(PhysW),
             .PhysRegCount(PhysRegCount), .CntW(CntW)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid),
    .flushValid(flushValid), .flushSeq(flushSeq),
    .retireValid(retireValid), .retireSeq(retireSeq),
    .isEmpty(isEmpty), .isFull(full), .youngRec(youngRec), .oldRec(oldRec),
    .strobe(strobe), .busy(busy),
    .mapWrEn(mapWrEn), .mapWrArch(mapWrArch), .mapWrPhys(mapWrPhys),
    .freeEn(freeEn), .freePhys(freePhys),
    .sbSetEn(sbSetEn), .sbSetPhys(sbSetPhys),
    .retireCnt(retireCnt), .undoCnt(undoCnt)
  );

  // R9
  busy_blocks_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !freeEn) |=> $stable(full));
endmodule

// File: tb/rename_history_buf_tb_top.sv
`timescale 1ns/1ps
module rename_history_buf_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, flushValid = 0, retireValid = 0;
  logic [7:0] pushSeq = 0, flushSeq = 0, retireSeq = 0;
  logic [4:0] pushArch = 0;
  logic [6:0] pushNew = 0, pushPrev = 0;
  logic busy, full, mapWrEn, freeEn, sbSetEn;
  logic [4:0] mapWrArch;
  logic [6:0] mapWrPhys, freePhys, sbSetPhys;
  logic [15:0] retireCnt, undoCnt;

  int total = 0, bad = 0;
  int sbHits = 0, lastSb = -1, lastMapArch = -1, lastMapPhys = -1;

  always #2.5 clk = ~clk;

  rename_history_buf dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushSeq(pushSeq),
    .pushArch(pushArch), .pushNew(pushNew), .pushPrev(pushPrev),
    .flushValid(flushValid), .flushSeq(flushSeq),
    .retireValid(retireValid), .retireSeq(retireSeq),
    .busy(busy), .full(full), .mapWrEn(mapWrEn), .mapWrArch(mapWrArch),
    .mapWrPhys(mapWrPhys), .freeEn(freeEn), .freePhys(freePhys),
    .sbSetEn(sbSetEn), .sbSetPhys(sbSetPhys),
    .retireCnt(retireCnt), .undoCnt(undoCnt)
  );

  typedef struct packed {
    logic [1:0] op;     // 0 push, 1 flush, 2 retire
    logic [7:0] seq;
    logic [4:0] arch;
    logic [6:0] newp;
    logic [6:0] prev;
    logic [3:0] expN;
    logic [7:0] expFirst; // 8'hFF when nothing is freed
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 8'd10, 5'd1, 7'd40,  7'd1,  4'd0, 8'hFF},
    '{2'd0, 8'd12, 5'd2, 7'd41,  7'd2,  4'd0, 8'hFF},
    '{2'd0, 8'd14, 5'd1, 7'd100, 7'd40, 4'd0, 8'hFF},
    '{2'd0, 8'd16, 5'd3, 7'd42,  7'd3,  4'd0, 8'hFF},
    '{2'd2, 8'd11, 5'd0, 7'd0,   7'd0,  4'd1, 8'd1},   // R6 partial retire
    '{2'd2, 8'd9,  5'd0, 7'd0,   7'd0,  4'd0, 8'hFF},  // R7 oldest too young
    '{2'd1, 8'd13, 5'd0, 7'd0,   7'd0,  4'd2, 8'd42},  // R3 mid-log flush
    '{2'd0, 8'd20, 5'd4, 7'd43,  7'd4,  4'd0, 8'hFF},
    '{2'd2, 8'd30, 5'd0, 7'd0,   7'd0,  4'd2, 8'd2},   // R6 full retire
    '{2'd2, 8'd5,  5'd0, 7'd0,   7'd0,  4'd0, 8'hFF}   // R7 empty log
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doPush(input logic [7:0] s, input logic [4:0] a,
                        input logic [6:0] n, input logic [6:0] p);
    @(negedge clk);
    pushValid = 1; pushSeq = s; pushArch = a; pushNew = n; pushPrev = p;
    @(negedge clk);
    pushValid = 0;
  endtask

  task automatic doWalk(input logic fl, input logic rt, input logic [7:0] fs,
                        input logic [7:0] rs, input logic pushMid,
                        output int nFree, output int firstFree);
    @(negedge clk);
    flushValid = fl; flushSeq = fs; retireValid = rt; retireSeq = rs;
    @(negedge clk);
    flushValid = 0; retireValid = 0;
    nFree = 0; firstFree = 255;
    if (pushMid) begin
      pushValid = 1; pushSeq = 8'd90; pushArch = 5'd9; pushNew = 7'd55; pushPrev = 7'd56;
    end
    for (int i = 0; i < 40 && busy; i++) begin
      if (freeEn) begin
        if (nFree == 0) firstFree = freePhys;
        nFree++;
        if (sbSetEn) begin sbHits++; lastSb = sbSetPhys; end
        if (mapWrEn) begin lastMapArch = mapWrArch; lastMapPhys = mapWrPhys; end
      end
      @(negedge clk);
      pushValid = 0;
    end
    pushValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, f;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 full", full, 0);
    check("R1 strobes", {mapWrEn, freeEn, sbSetEn}, 0);
    check("R1 counters", retireCnt + undoCnt, 0);
    rstN = 1;

    foreach (VECS[k]) begin
      if (VECS[k].op == 2'd0) begin
        doPush(VECS[k].seq, VECS[k].arch, VECS[k].newp, VECS[k].prev);
      end else begin
        doWalk(VECS[k].op == 2'd1, VECS[k].op == 2'd2, VECS[k].seq, VECS[k].seq,
               1'b0, n, f);
        check($sformatf("R3/R6/R7 vec%0d count", k), n, VECS[k].expN);
        check($sformatf("R3/R6/R7 vec%0d first", k), f, VECS[k].expFirst);
        if (k == 6) begin
          // R4 last restore is seq 14: arch 1 back to 40
          check("R4 map arch", lastMapArch, 1);
          check("R4 map phys", lastMapPhys, 40);
          // R5 only register 100 is at or above 96
          check("R5 sb hits", sbHits, 1);
          check("R5 sb phys", lastSb, 100);
        end
      end
    end

    // R2 fill to capacity, extra push dropped
    for (int i = 0; i < 8; i++) doPush(8'(40 + i), 5'(i), 7'(60 + i), 7'(i));
    check("R2 full set", full, 1);
    doPush(8'd48, 5'd9, 7'd77, 7'd78);
    doWalk(1'b1, 1'b0, 8'd0, 8'd0, 1'b0, n, f);
    check("R2 flush all count", n, 8);
    check("R2 dropped push absent", f, 67);
    check("R2 full clear", full, 0);

    // R8 flush and retire together
    doPush(8'd50, 5'd5, 7'd20, 7'd21);
    doPush(8'd52, 5'd6, 7'd22, 7'd23);
    doWalk(1'b1, 1'b1, 8'd51, 8'd60, 1'b0, n, f);
    check("R8 flush only count", n, 1);
    check("R8 flush only first", f, 22);
    doWalk(1'b1, 1'b0, 8'd0, 8'd0, 1'b0, n, f);
    check("R8 retire ignored", f, 20);

    // R9 push during a walk is dropped
    doPush(8'd70, 5'd7, 7'd33, 7'd30);
    doPush(8'd72, 5'd8, 7'd34, 7'd31);
    doPush(8'd74, 5'd7, 7'd35, 7'd32);
    doWalk(1'b0, 1'b1, 8'd0, 8'd80, 1'b1, n, f);
    check("R9 retire walk count", n, 3);
    check("R9 retire first", f, 30);
    doWalk(1'b1, 1'b0, 8'd0, 8'd0, 1'b0, n, f);
    check("R9 busy push dropped", n, 0);

    // R10 totals
    check("R10 retireCnt", retireCnt, 6);
    check("R10 undoCnt", undoCnt, 12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule